// File: doc/BRIEF.md
# Four-Phase Accumulator Control Unit

This block is the sequencing and command section of a small accumulator machine. A two-bit phase counter walks every instruction through four clock cycles: fetch, program-counter advance, first execute, second execute. The upper five bits of the instruction register are decoded into one of three memory-referencing instructions or one of eight register-only instructions. Each datapath command is then formed as a plain product of a phase line and a decoded instruction line. The commands are combinational. The datapath samples them on the rising edge that closes the phase.

A halt instruction freezes the sequencer at the fetch phase, and a front-panel start input resumes it. The initialise input puts the counter back at the fetch phase from any state and lets it run. The datapath itself (the program counter, the accumulator, the instruction register and the memory) lies outside this block. The block sees only the accumulator's lowest and highest bits, which it needs for the two conditional skips.

Top module: `phase_ctrl`

## Requirements
- R1: With `init` high at a rising edge, the next state is the fetch phase (`phase_oh`=0001) with `run`=1. This holds from any phase, and from the halted state.
- R2: While `run`=1, one phase passes per clock in the order fetch, advance, execute-1, execute-2, then back to fetch. `phase_oh` bit 0 marks fetch, bit 1 advance, bit 2 execute-1 and bit 3 execute-2. Every instruction therefore takes exactly four cycles.
- R3: In fetch, only `ld_ir` is high, and `sel_addr`=0 so that memory is addressed by the program counter. In the advance phase, only `inc_pc` is high.
- R4: `op` carries instruction-register bits 7..3. Major code `op[4:3]` 01 is a jump, which raises `ld_pc` in execute-1 and nothing in execute-2.
- R5: Major code 10 is an add. It raises `sel_addr` in both execute phases and `ld_acc` in execute-2, with `sel_logic`=0.
- R6: Major code 11 is a store. It raises `sel_addr` in both execute phases and `wr_mem` in execute-2, and `ld_acc` stays low.
- R7: Under major code 00, the minor code `op[2:0]` selects the instruction. Code 001 (clear) raises `clr_acc` in execute-1 only. Code 000 (no-op) raises no command in either execute phase.
- R8: Minor codes 010 (complement), 011 (shift right) and 100 (shift left) raise `sel_logic` in both execute phases, with `shift_sel` equal to 01, 10 or 11 respectively, and raise `ld_acc` in execute-2.
- R9: Minor code 101 raises `inc_pc` in execute-2 only if `acc_lsb`=1. Minor code 110 does the same only if `acc_msb`=1. Otherwise both raise no command.
- R10: Minor code 111 (halt) raises no command. After its execute-2, `run` is 0 and `phase_oh` stays at 0001 with every command low until a start.
- R11: While halted, `start`=1 at an edge sets `run`=1. The following cycle is a fetch.
- R12: `start` has no effect while running. The phase sequence and the commands continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock |
| init | input | 1 | Synchronous initialise, active high |
| start | input | 1 | Resume after halt |
| op | input | 5 | Instruction register bits 7..3 |
| acc_lsb | input | 1 | Accumulator bit 0 |
| acc_msb | input | 1 | Accumulator bit 7 |
| phase_oh | output | 4 | One-hot current phase |
| run | output | 1 | Sequencer running |
| ld_ir | output | 1 | Load instruction register |
| inc_pc | output | 1 | Increment program counter |
| ld_pc | output | 1 | Load program counter from address field |
| sel_addr | output | 1 | Memory address from address field (1) or program counter (0) |
| sel_logic | output | 1 | Accumulator input from logic/shift unit (1) or adder (0) |
| shift_sel | output | 2 | 01 complement, 10 shift right, 11 shift left |
| ld_acc | output | 1 | Load accumulator |
| clr_acc | output | 1 | Clear accumulator |
| wr_mem | output | 1 | Write accumulator to memory |

## Verification
The hardest state to reach is the halted state combined with start activity. It exists only after a halt instruction has been presented through a complete four-phase pass. The bench runs the halt instruction in step with the phases and then idles with start low, checking that the phase and every command stay frozen. It then pulses start and requires a fetch on the very next cycle. The conditional skips are driven with each accumulator bit at both values, so that both the taken and the not-taken cases are seen in execute-2.

// File: rtl/phase_ctrl.sv
module phase_ctrl (
  input  logic       clk,
  input  logic       init,
  input  logic       start,
  input  logic [4:0] op,
  input  logic       acc_lsb,
  input  logic       acc_msb,
  output logic [3:0] phase_oh,
  output logic       run,
  output logic       ld_ir,
  output logic       inc_pc,
  output logic       ld_pc,
  output logic       sel_addr,
  output logic       sel_logic,
  output logic [1:0] shift_sel,
  output logic       ld_acc,
  output logic       clr_acc,
  output logic       wr_mem
);
  logic [1:0] cnt;
  logic       run_q;
  logic [3:0] maj;
  logic [7:0] mnr;
  logic       f, a, x1, x2;

  assign phase_oh = 4'b0001 << cnt;
  assign run      = run_q;

  assign f  = run_q & phase_oh[0];
  assign a  = run_q & phase_oh[1];
  assign x1 = run_q & phase_oh[2];
  assign x2 = run_q & phase_oh[3];

  assign maj = 4'b0001 << op[4:3];
  assign mnr = maj[0] ? (8'b0000_0001 << op[2:0]) : 8'b0;

  logic d_jmp, d_add, d_mem, d_cla, d_cpl, d_shr, d_shl, d_sko, d_skn, d_stp;
  assign d_jmp = maj[1];
  assign d_add = maj[2];
  assign d_mem = maj[3];
  assign d_cla = mnr[1];
  assign d_cpl = mnr[2];
  assign d_shr = mnr[3];
  assign d_shl = mnr[4];
  assign d_sko = mnr[5];
  assign d_skn = mnr[6];
  assign d_stp = mnr[7];

  logic xa, unit;
  assign xa   = x1 | x2;
  assign unit = d_cpl | d_shr | d_shl;

  assign ld_ir     = f;
  assign inc_pc    = a | (x2 & ((d_sko & acc_lsb) | (d_skn & acc_msb)));
  assign ld_pc     = x1 & d_jmp;
  assign sel_addr  = xa & (d_add | d_mem);
  assign sel_logic = xa & unit;
  assign shift_sel = xa ? {d_shr | d_shl, d_cpl | d_shl} : 2'b00;
  assign ld_acc    = x2 & (d_add | unit);
  assign clr_acc   = x1 & d_cla;
  assign wr_mem    = x2 & d_mem;

  always_ff @(posedge clk) begin
    if (init) begin
      cnt   <= 2'd0;
      run_q <= 1'b1;
    end else if (run_q) begin
      cnt <= cnt + 2'd1;
      if (x2 & d_stp) run_q <= 1'b0;
    end else if (start) begin
      run_q <= 1'b1;
    end
  end
endmodule

// File: rtl/phase_ctrl_chk.sv
module phase_ctrl_chk (
  input logic       clk,
  input logic       init,
  input logic [4:0] op,
  input logic [3:0] phase_oh,
  input logic       run,
  input logic       ld_ir,
  input logic       inc_pc,
  input logic       ld_pc,
  input logic       sel_addr,
  input logic       sel_logic,
  input logic [1:0] shift_sel,
  input logic       ld_acc,
  input logic       clr_acc,
  input logic       wr_mem
);
  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (init)
    $countones(phase_oh) == 1); // R2
  AST_PHASE_ROTATE: assert property (@(posedge clk) disable iff (init)
    run |=> phase_oh == {$past(phase_oh[2:0]), $past(phase_oh[3])}); // R2
  AST_FETCH_ONLY_LDIR: assert property (@(posedge clk) disable iff (init)
    ld_ir |-> phase_oh[0] && !sel_addr); // R3
  AST_STORE_IN_E2: assert property (@(posedge clk) disable iff (init)
    wr_mem |-> phase_oh[3] && sel_addr && !ld_acc); // R6
  AST_HALT_STOPS: assert property (@(posedge clk) disable iff (init)
    (run && phase_oh[3] && op == 5'b00111) |=> !run && phase_oh[0]); // R10
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (init)
    !run |-> !(ld_ir | inc_pc | ld_pc | sel_addr | sel_logic | ld_acc | clr_acc | wr_mem)
             && shift_sel == 2'b00); // R10
endmodule

bind phase_ctrl phase_ctrl_chk u_chk (
  .clk(clk), .init(init), .op(op), .phase_oh(phase_oh), .run(run),
  .ld_ir(ld_ir), .inc_pc(inc_pc), .ld_pc(ld_pc), .sel_addr(sel_addr),
  .sel_logic(sel_logic), .shift_sel(shift_sel), .ld_acc(ld_acc),
  .clr_acc(clr_acc), .wr_mem(wr_mem)
);

// File: tb/sim_phase_ctrl.sv
module sim_phase_ctrl;
  logic clk = 1'b0;
  logic init = 1'b1, start = 1'b0, acc_lsb = 1'b0, acc_msb = 1'b0;
  logic [4:0] op = 5'b0;
  logic [3:0] phase_oh;
  logic run, ld_ir, inc_pc, ld_pc, sel_addr, sel_logic, ld_acc, clr_acc, wr_mem;
  logic [1:0] shift_sel;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  phase_ctrl u0 (.clk(clk), .init(init), .start(start), .op(op), .acc_lsb(acc_lsb),
    .acc_msb(acc_msb), .phase_oh(phase_oh), .run(run), .ld_ir(ld_ir), .inc_pc(inc_pc),
    .ld_pc(ld_pc), .sel_addr(sel_addr), .sel_logic(sel_logic), .shift_sel(shift_sel),
    .ld_acc(ld_acc), .clr_acc(clr_acc), .wr_mem(wr_mem));

  // order: ld_ir inc_pc ld_pc sel_addr sel_logic shift_sel[1:0] ld_acc clr_acc wr_mem
  wire [9:0] cmds = {ld_ir, inc_pc, ld_pc, sel_addr, sel_logic, shift_sel, ld_acc, clr_acc, wr_mem};

  localparam logic [9:0] V_I1 = 10'b1000000000, V_I2 = 10'b0100000000, V_0 = 10'b0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic instr(input string tag, input logic [4:0] o, input logic l, input logic m,
                       input logic [9:0] e1, input logic [9:0] e2);
    op = o; acc_lsb = l; acc_msb = m;
    chk({tag, " R3 fetch phase"}, {11'b0, run, phase_oh}, {11'b0, 1'b1, 4'b0001});
    chk({tag, " R3 fetch cmds"}, {6'b0, cmds}, {6'b0, V_I1});
    tick;
    chk({tag, " R2 advance phase"}, {12'b0, phase_oh}, 16'h0002);
    chk({tag, " R3 advance cmds"}, {6'b0, cmds}, {6'b0, V_I2});
    tick;
    chk({tag, " R2 exec1 phase"}, {12'b0, phase_oh}, 16'h0004);
    chk({tag, " exec1 cmds"}, {6'b0, cmds}, {6'b0, e1});
    tick;
    chk({tag, " R2 exec2 phase"}, {12'b0, phase_oh}, 16'h0008);
    chk({tag, " exec2 cmds"}, {6'b0, cmds}, {6'b0, e2});
    tick;
  endtask

  task automatic t_reset;
    init = 1'b1; tick; tick;
    chk("R1 reset phase/run", {11'b0, run, phase_oh}, {11'b0, 1'b1, 4'b0001});
    init = 1'b0;
  endtask

  task automatic t_memref;
    instr("R4 jump", 5'b01101, 0, 0, 10'b0010000000, V_0);
    instr("R5 add", 5'b10010, 0, 0, 10'b0001000000, 10'b0001000100);
    instr("R6 store", 5'b11111, 0, 0, 10'b0001000000, 10'b0001000001);
  endtask

  task automatic t_regops;
    instr("R7 nop", 5'b00000, 1, 1, V_0, V_0);
    instr("R7 clear", 5'b00001, 0, 0, 10'b0000000010, V_0);
    instr("R8 complement", 5'b00010, 0, 0, 10'b0000101000, 10'b0000101100);
    instr("R8 shift right", 5'b00011, 0, 0, 10'b0000110000, 10'b0000110100);
    instr("R8 shift left", 5'b00100, 0, 0, 10'b0000111000, 10'b0000111100);
  endtask

  task automatic t_skips;
    instr("R9 skip lsb taken", 5'b00101, 1, 0, V_0, V_I2);
    instr("R9 skip lsb not taken", 5'b00101, 0, 1, V_0, V_0);
    instr("R9 skip msb taken", 5'b00110, 0, 1, V_0, V_I2);
    instr("R9 skip msb not taken", 5'b00110, 1, 0, V_0, V_0);
  endtask

  task automatic t_halt_start;
    instr("R10 halt", 5'b00111, 1, 1, V_0, V_0);
    for (int k = 0; k < 3; k++) begin
      chk("R10 halted run/phase", {11'b0, run, phase_oh}, {11'b0, 1'b0, 4'b0001});
      chk("R10 halted cmds", {6'b0, cmds}, 16'h0);
      tick;
    end
    start = 1'b1; tick; start = 1'b0;
    chk("R11 resumed run/phase", {11'b0, run, phase_oh}, {11'b0, 1'b1, 4'b0001});
    chk("R11 resumed fetch", {6'b0, cmds}, {6'b0, V_I1});
    start = 1'b1;
    instr("R12 start while running", 5'b10000, 0, 0, 10'b0001000000, 10'b0001000100);
    start = 1'b0;
    chk("R12 still running", {15'b0, run}, 16'h1);
  endtask

  task automatic t_init_mid;
    op = 5'b01000; tick; tick;
    chk("R1 reached exec1", {12'b0, phase_oh}, 16'h0004);
    init = 1'b1; tick; init = 1'b0;
    chk("R1 init mid-instr", {11'b0, run, phase_oh}, {11'b0, 1'b1, 4'b0001});
    instr("R10 halt again", 5'b00111, 0, 0, V_0, V_0);
    init = 1'b1; tick; init = 1'b0;
    chk("R1 init from halt", {11'b0, run, phase_oh}, {11'b0, 1'b1, 4'b0001});
  endtask

  initial begin
    t_reset;
    t_memref;
    t_regops;
    t_skips;
    t_halt_start;
    t_init_mid;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule